// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a chain of 4-bit synchronous up-counter stages that together form one wider binary counter. Each stage can be preloaded from a parallel data word, can count up by one, or can keep its value. An active-low master clear forces every stage to zero at once, with no clock edge needed. Each stage has two count enables: a parallel enable and a trickle enable. Its terminal-count output is high when the trickle enable is high and the stage holds all ones.

Stages chain through a look-ahead carry. The common count enable drives every parallel enable. Stage 0 takes its trickle enable from the chain input, and each later stage takes its trickle enable from the terminal count of the stage below. The chain therefore counts through every value of its full width and then wraps.

Each stage chooses one of four named operations:
- CLEAR: the asynchronous clear is asserted.
- LOAD: the load strobe is low at a rising edge.
- COUNT: the load strobe is high and both enables are high.
- HOLD: any other case.

The transitions are CLEAR to the stage's zero state, LOAD to the parallel data, COUNT to the current value plus one, and HOLD back to the same value.

Top module: `bincnt_chain`

## Requirements
- R1: While `rst_n` is low, `q` is all zeros. The clear acts as soon as `rst_n` falls, with no clock edge, and it overrides `load_n`, both enables and the clock.
- R2: At a rising edge where `load_n` is low, `q` takes the value of `din`, whatever the enables are.
- R3: At a rising edge where `load_n`, `cnt_en` and `chain_en` are all high, the whole chain increments by one.
- R4: At a rising edge where `load_n` is high and either `cnt_en` or `chain_en` is low, `q` keeps its value.
- R5: A stage that holds 15 and counts goes to 0 on that edge.
- R6: `stage_tc[k]` is high exactly when stage k's trickle enable is high and its nibble `q[4k+3:4k]` is all ones. It does not depend on `cnt_en` or `load_n`.
- R7: Stage k>0 counts only when every lower stage holds 15. The chain counts 0 through 2^(4N)-1 and then wraps to 0.
- R8: `carry_out` equals `stage_tc[N-1]`. During continuous counting it is high for exactly one clock period per full cycle of the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change except the clear happens on its rising edge |
| rst_n | input | 1 | Active-low asynchronous master clear |
| load_n | input | 1 | Active-low synchronous parallel load strobe |
| din | input | 4*N | Parallel load data; stage k uses bits 4k+3:4k |
| cnt_en | input | 1 | Common parallel count enable for all stages |
| chain_en | input | 1 | Trickle enable of stage 0 |
| q | output | 4*N | Counter state; stage k drives bits 4k+3:4k |
| stage_tc | output | N | Terminal count of each stage |
| carry_out | output | 1 | Terminal count of the top stage, used to cascade further |

## Verification
The hardest case to reach from the ports is a terminal count from an upper stage. It requires every lower nibble to be all ones at the same time, which plain counting from reset reaches only once every 2^(4N) cycles. The stimulus gets there by loading 0x0F and 0xFF directly and then counting across the boundary. A full sweep of more than 2^(4N) counts then confirms the wrap and the single-period carry pulse. The asynchronous clear is applied in the middle of a clock period, with load and both enables active. This shows that `q` drops at once and stays at zero through a later edge.

// File: rtl/bincnt_pkg.sv
`timescale 1ns/1ps
package bincnt_pkg;

    // Operation selected by a stage for the next rising edge
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2
    } cnt_op_e;

    localparam int STAGE_W = 4;

endpackage

// File: rtl/bincnt_opsel.sv
`timescale 1ns/1ps
module bincnt_opsel
    import bincnt_pkg::*;
(
    input  logic    load_n,
    input  logic    par_en,
    input  logic    trk_en,
    output cnt_op_e op
);

    // Load wins over counting and needs no enable
    always_comb begin
        if (!load_n)
            op = OP_LOAD;
        else if (par_en && trk_en)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/bincnt_stage.sv
`timescale 1ns/1ps
module bincnt_stage
    import bincnt_pkg::*;
#(
    parameter int W = STAGE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n,
    input  logic [W-1:0] din,
    input  logic         par_en,
    input  logic         trk_en,
    output logic [W-1:0] q,
    output logic         tc
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    cnt_op_e op;

    bincnt_opsel u_opsel (
        .load_n (load_n),
        .par_en (par_en),
        .trk_en (trk_en),
        .op     (op)
    );

    // State register: asynchronous clear, then the selected operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (op)
                OP_LOAD:  q <= din;
                OP_COUNT: q <= q + 1'b1;
                OP_HOLD:  q <= q;
                default:  q <= q;
            endcase
        end
    end

    // Output process: look-ahead terminal count, independent of par_en
    always_comb begin
        tc = trk_en && (q == ALL_ONES);
    end

    // R2
    load_takes_din_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> q == $past(din));

    // R3
    count_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && par_en && trk_en) |=> q == W'($past(q) + 1'b1));

    // R4
    hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(par_en && trk_en)) |=> $stable(q));

    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && par_en && tc) |=> q == '0);

endmodule

// File: rtl/bincnt_chain.sv
`timescale 1ns/1ps
module bincnt_chain
    import bincnt_pkg::*;
#(
    parameter int N = 2,
    parameter int W = STAGE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_n,
    input  logic [N*W-1:0] din,
    input  logic           cnt_en,
    input  logic           chain_en,
    output logic [N*W-1:0] q,
    output logic [N-1:0]   stage_tc,
    output logic           carry_out
);

    localparam int TOT = N * W;

    // Trickle enable seen by each stage
    logic [N-1:0] trk;

    for (genvar k = 0; k < N; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign trk[k] = chain_en;
        end else begin : g_next
            assign trk[k] = stage_tc[k-1];
        end

        bincnt_stage #(.W(W)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_n (load_n),
            .din    (din[k*W +: W]),
            .par_en (cnt_en),
            .trk_en (trk[k]),
            .q      (q[k*W +: W]),
            .tc     (stage_tc[k])
        );
    end

    assign carry_out = stage_tc[N-1];

    // R7
    chain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en && chain_en) |=> q == TOT'($past(q) + 1'b1));

    // R8
    carry_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_out && load_n && cnt_en) |=> !carry_out);

    // R1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clear_zero_chk: assert (q == '0);
        end
    end

endmodule

// File: tb/bincnt_chain_test.sv
`timescale 1ns/1ps
module bincnt_chain_test;

    localparam int W = 4;
    localparam int N = 2;
    localparam int T = N * W;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         load_n = 1'b1;
    logic [T-1:0] din = '0;
    logic         cnt_en = 1'b0;
    logic         chain_en = 1'b0;
    logic [T-1:0] q;
    logic [N-1:0] stage_tc;
    logic         carry_out;

    bincnt_chain #(.N(N), .W(W)) uut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
        .cnt_en(cnt_en), .chain_en(chain_en),
        .q(q), .stage_tc(stage_tc), .carry_out(carry_out)
    );

    typedef struct {
        logic [T-1:0] q;
        logic [N-1:0] tc;
        logic         co;
        string        tag;
    } exp_t;

    exp_t         sbq[$];
    int           n_cmp = 0;
    int           n_bad = 0;
    logic [T-1:0] mdl = '0;

    function automatic logic [N-1:0] model_tc(logic [T-1:0] v, logic te);
        logic [N-1:0] r;
        logic t;
        t = te;
        for (int k = 0; k < N; k++) begin
            r[k] = t && (v[k*W +: W] == {W{1'b1}});
            t = r[k];
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Driver: apply inputs away from the edge, push the state due after it
    task automatic step(bit ld_n, logic [T-1:0] d, bit ce, bit te, string tag);
        exp_t e;
        @(negedge clk);
        load_n = ld_n; din = d; cnt_en = ce; chain_en = te;
        if (!ld_n) mdl = d;
        else if (ce && te) mdl = mdl + 1'b1;
        e.q = mdl;
        e.tc = model_tc(mdl, te);
        e.co = e.tc[N-1];
        e.tag = tag;
        sbq.push_back(e);
    endtask

    // Monitor: compare one item after every rising edge
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (sbq.size() > 0) begin
            e = sbq.pop_front();
            chk({e.tag, " q"}, 32'(q), 32'(e.q));
            chk({e.tag, " R6 stage_tc"}, 32'(stage_tc), 32'(e.tc));
            chk({e.tag, " R8 carry_out"}, 32'(carry_out), 32'(e.co));
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset state q", 32'(q), 0);
        chk("R1 reset state carry_out", 32'(carry_out), 0);
        @(negedge clk);
        rst_n = 1'b1;

        repeat (3) step(1, 8'h00, 0, 1, "R4 hold parallel low");
        step(0, 8'h5A, 1, 1, "R2 load beats count");
        step(0, 8'h3C, 0, 0, "R2 load without enables");
        repeat (2) step(1, 8'h00, 1, 0, "R4 hold trickle low");
        step(1, 8'h00, 0, 1, "R4 hold parallel low");
        step(0, 8'h0F, 0, 0, "R2 load 0F");
        step(1, 8'h00, 0, 1, "R6 tc without parallel");
        step(1, 8'h00, 0, 0, "R6 tc gated by trickle");
        step(1, 8'h00, 1, 1, "R7 carry into upper");
        step(0, 8'h0E, 0, 0, "R2 load 0E");
        repeat (3) step(1, 8'h00, 1, 1, "R5 lower wrap");
        step(0, 8'hFF, 0, 0, "R2 load FF");
        step(1, 8'h00, 0, 1, "R8 carry while holding");
        step(1, 8'h00, 1, 1, "R5 R7 full wrap");
        step(0, 8'hF0, 1, 0, "R2 load F0");
        step(1, 8'h00, 1, 1, "R6 upper F lower not");
        repeat (300) step(1, 8'h00, 1, 1, "R7 full sweep");

        // Clear asserted in the middle of a period
        @(posedge clk);
        #1.5;
        rst_n = 1'b0;
        #0.3;
        chk("R1 clear without edge q", 32'(q), 0);
        load_n = 1'b0; din = 8'hAA; cnt_en = 1'b1; chain_en = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 clear overrides load and enables", 32'(q), 0);
        chk("R1 clear carry_out", 32'(carry_out), 0);
        mdl = '0;
        @(negedge clk);
        load_n = 1'b1; cnt_en = 1'b0;
        rst_n = 1'b1;

        repeat (4) step(1, 8'h00, 1, 1, "R3 count after clear");
        step(0, 8'hC7, 1, 1, "R2 load C7");
        repeat (10) step(1, 8'h00, 1, 1, "R3 count C7 onward");
        step(1, 8'h00, 1, 0, "R4 hold chain low");

        wait (sbq.size() == 0);
        @(posedge clk);
        #2;
        summary();
        $finish;
    end

endmodule